// File: doc/BRIEF.md
# Seeded pseudo-random word generator with register interface

This peripheral sits on a simple synchronous 32-bit register bus. Software first loads five seed words. It then selects the generator mode and issues a start request in a single control write. When every seed slot has been loaded, the block produces five fresh 32-bit pseudo-random words. Software can then read those words from a read-only bank. A status word reports several things: whether the seeds are complete, whether a generation finished, and three flags that software can overwrite.

The generator is a 32-bit xorshift state. Each seed write reloads the state with the XOR of the five seed registers. Each generation then advances the state five times, so later generations continue the sequence and do not repeat it. Generation finishes in the clock edge that takes the triggering write. The block is never busy, and the read port has one register stage.

Top module: `seeded_prng_regs`

## Requirements
- R1: After reset the control word reads 0x0, the status word reads 0x1 and all five output words read 0.
- R2: A write to seed slot n (byte address 0x140 + 4·n, n = 0..4) marks that slot as loaded. Status bit 1 reads 1 only once all five slots have been loaded since reset.
- R3: A write to the control word (address 0x0) whose bit 3 and bit 4 are both 1 triggers a generation, provided status bit 1 is already 1. A generation replaces all five output words and sets status bit 5. A control write that lacks any of these conditions leaves the output words and status bit 5 unchanged.
- R4: After any control write, control bit 4 reads 0 and every other control bit reads back as written.
- R5: A write to the status word (address 0x10) copies written bits 5, 4 and 3 into status bits 5, 4 and 3. The write has no effect on any other status bit.
- R6: Every seed write loads the generator state with the XOR of the five seed registers; a slot that has never been written counts as 0. If that XOR is zero, the value 0x00000001 is loaded instead. One step is x ^= x<<13; x ^= x>>17; x ^= x<<5 on 32 bits. Output word n (address 0x160 + 4·n) receives the state after n+1 steps.
- R7: After a generation the state is the value written to output word 4. The next generation continues from that state.
- R8: Reads of any address other than the control word, the status word and the five output words return 0. This includes the seed slots. Writes to any address other than the control word, the status word and the seed slots change nothing. This includes the output words and misaligned addresses.
- R9: rd_data_o presents the addressed value one clock after rd_en_i is sampled high. It reads 0 after a cycle in which rd_en_i was low.
- R10: Status bit 0 always reads 1. Status bits 2 and 7, and bit 6 along with bits 31..8, always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 9 | Byte address within the 0x200-byte window |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe, sampled on the rising edge |
| rd_data_o | output | 32 | Registered read data |

## Verification
A write takes effect at the rising edge that samples it. A read request sampled at the next edge therefore already sees the new control, status, seed-complete and output values. rd_data_o is valid from that edge until the following one. The bench drives every access on the falling edge, holds it for one full cycle and samples rd_data_o at the next falling edge. A read issued right after a write therefore checks exactly the one-cycle result. Expected values come from an arithmetic model of the register rules and of the xorshift recurrence.

// File: rtl/prng_pkg.sv
package prng_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 9;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 9'h000;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 9'h010;
  localparam logic [ADDR_W-1:0] SEED_BASE = 9'h140;
  localparam logic [ADDR_W-1:0] OUT_BASE  = 9'h160;

  localparam int unsigned CTRL_MODE = 3;
  localparam int unsigned CTRL_GO   = 4;

  localparam int unsigned ST_RDY  = 0;
  localparam int unsigned ST_SEED = 1;
  localparam int unsigned ST_BUSY = 2;
  localparam int unsigned ST_PART = 3;
  localparam int unsigned ST_MSG  = 4;
  localparam int unsigned ST_DONE = 5;
  localparam int unsigned ST_ERR  = 7;

  localparam logic [DATA_W-1:0] ZERO_SUB = 32'h0000_0001;

  function automatic logic [DATA_W-1:0] xs_step(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction
endpackage

// File: rtl/prng_seed_bank.sv
module prng_seed_bank
  import prng_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WORDS-1:0] sel_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic                 all_set_o,
  output logic [DATA_W-1:0]    fold_o
);
  logic [NUM_WORDS-1:0][DATA_W-1:0] seed_q;
  logic [NUM_WORDS-1:0][DATA_W-1:0] view;
  logic [NUM_WORDS:0][DATA_W-1:0]   acc;
  logic [NUM_WORDS-1:0]             seen_q;

  assign acc[0] = '0;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       seed_q[k] <= '0;
      else if (sel_i[k]) seed_q[k] <= data_i;
    end
    // fold sees the word being written this cycle
    assign view[k]  = sel_i[k] ? data_i : seed_q[k];
    assign acc[k+1] = acc[k] ^ view[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= '0;
    else if (|sel_i) seen_q <= seen_q | sel_i;
  end

  assign all_set_o = &seen_q;
  assign fold_o    = acc[NUM_WORDS];
endmodule

// File: rtl/prng_core.sv
module prng_core
  import prng_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [DATA_W-1:0]                seed_i,
  input  logic                             gen_i,
  output logic [NUM_WORDS-1:0][DATA_W-1:0] words_o
);
  logic [DATA_W-1:0]                state_q;
  logic [DATA_W-1:0]                seed_nz;
  logic [NUM_WORDS-1:0][DATA_W-1:0] chain;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words_q;

  assign seed_nz  = (seed_i == '0) ? ZERO_SUB : seed_i;
  assign chain[0] = xs_step(state_q);

  for (genvar k = 1; k < NUM_WORDS; k++) begin : g_step
    assign chain[k] = xs_step(chain[k-1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ZERO_SUB;
      words_q <= '0;
    end else if (load_i) begin
      state_q <= seed_nz;
    end else if (gen_i) begin
      state_q <= chain[NUM_WORDS-1];
      words_q <= chain;
    end
  end

  assign words_o = words_q;
endmodule

// File: rtl/prng_rd_port.sv
module prng_rd_port
  import prng_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             rd_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                ctrl_i,
  input  logic [DATA_W-1:0]                status_i,
  input  logic [NUM_WORDS-1:0][DATA_W-1:0] words_i,
  output logic [DATA_W-1:0]                rd_data_o
);
  logic [DATA_W-1:0] sel_val;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    sel_val = '0;
    if (addr_i == CTRL_ADDR) sel_val = ctrl_i;
    if (addr_i == STAT_ADDR) sel_val = status_i;
    for (int k = 0; k < int'(NUM_WORDS); k++) begin
      if (addr_i == OUT_BASE + ADDR_W'(4 * k)) sel_val = words_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_en_i ? sel_val : '0;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/seeded_prng_regs.sv
module seeded_prng_regs
  import prng_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0]                ctrl_q;
  logic [2:0]                       sw_q;
  logic [DATA_W-1:0]                status_w;
  logic [NUM_WORDS-1:0]             seed_sel;
  logic                             seed_all;
  logic [DATA_W-1:0]                seed_fold;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic                             ctrl_wr;
  logic                             stat_wr;
  logic                             gen_fire;

  assign ctrl_wr = wr_en_i && (addr_i == CTRL_ADDR);
  assign stat_wr = wr_en_i && (addr_i == STAT_ADDR);

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_dec
    assign seed_sel[k] = wr_en_i && (addr_i == SEED_BASE + ADDR_W'(4 * k));
  end

  assign gen_fire = ctrl_wr && wr_data_i[CTRL_MODE] && wr_data_i[CTRL_GO] && seed_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q          <= wr_data_i;
      ctrl_q[CTRL_GO] <= 1'b0;
    end
  end

  // sw_q = {done, msg, partial}
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sw_q <= '0;
    else if (stat_wr)  sw_q <= wr_data_i[ST_DONE:ST_PART];
    else if (gen_fire) sw_q[2] <= 1'b1;
  end

  always_comb begin
    status_w          = '0;
    status_w[ST_RDY]  = 1'b1;
    status_w[ST_SEED] = seed_all;
    status_w[ST_BUSY] = 1'b0;
    status_w[ST_PART] = sw_q[0];
    status_w[ST_MSG]  = sw_q[1];
    status_w[ST_DONE] = sw_q[2];
    status_w[ST_ERR]  = 1'b0;
  end

  prng_seed_bank #(.NUM_WORDS(NUM_WORDS)) u_seed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (seed_sel),
    .data_i    (wr_data_i),
    .all_set_o (seed_all),
    .fold_o    (seed_fold)
  );

  prng_core #(.NUM_WORDS(NUM_WORDS)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (|seed_sel),
    .seed_i  (seed_fold),
    .gen_i   (gen_fire),
    .words_o (words)
  );

  prng_rd_port #(.NUM_WORDS(NUM_WORDS)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .ctrl_i    (ctrl_q),
    .status_i  (status_w),
    .words_i   (words),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/seeded_prng_regs_chk.sv
module seeded_prng_regs_chk
  import prng_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [ADDR_W-1:0]                addr_i,
  input logic                             wr_en_i,
  input logic [DATA_W-1:0]                wr_data_i,
  input logic                             rd_en_i,
  input logic [DATA_W-1:0]                rd_data_o,
  input logic [DATA_W-1:0]                ctrl_q,
  input logic [DATA_W-1:0]                status_w,
  input logic                             seed_all,
  input logic [NUM_WORDS-1:0][DATA_W-1:0] words
);
  localparam logic [ADDR_W-1:0] SEED_END = SEED_BASE + ADDR_W'(4 * NUM_WORDS);

  logic is_ctrl, is_stat, is_seed, go_req;
  assign is_ctrl = addr_i == CTRL_ADDR;
  assign is_stat = addr_i == STAT_ADDR;
  assign is_seed = (addr_i >= SEED_BASE) && (addr_i < SEED_END) && (addr_i[1:0] == 2'b00);
  assign go_req  = wr_data_i[CTRL_MODE] && wr_data_i[CTRL_GO];

  assert_go_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_ctrl) |=> (!ctrl_q[CTRL_GO] && ctrl_q[CTRL_MODE] == $past(wr_data_i[CTRL_MODE])));

  assert_done_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_ctrl && go_req && seed_all) |=> status_w[ST_DONE]);

  assert_no_gen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_ctrl && !(go_req && seed_all)) |=> $stable(words));

  assert_seed_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seed_all) |-> $past(wr_en_i && is_seed));

  assert_dead_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !is_ctrl && !is_stat && !is_seed) |=>
      ($stable(ctrl_q) && $stable(status_w) && $stable(words)));

  assert_idle_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rd_data_o == '0));

  assert_fixed_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_w[ST_RDY] && !status_w[ST_BUSY] && !status_w[ST_ERR]));
endmodule

bind seeded_prng_regs seeded_prng_regs_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .ctrl_q    (ctrl_q),
  .status_w  (status_w),
  .seed_all  (seed_all),
  .words     (words)
);

// File: tb/seeded_prng_regs_tb.sv
`timescale 1ns/1ps
module seeded_prng_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  seeded_prng_regs u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o)
  );

  // reference model
  logic [31:0] m_ctrl, m_state;
  logic [2:0]  m_sw;
  logic [4:0]  m_seen;
  logic [31:0] m_seed [5];
  logic [31:0] m_out [5];

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  function automatic logic [31:0] m_read(input logic [8:0] a);
    if (a == 9'h000) return m_ctrl;
    if (a == 9'h010) return {26'd0, m_sw, 1'b0, (m_seen == 5'h1f), 1'b1};
    for (int k = 0; k < 5; k++) if (a == 9'h160 + 9'(4 * k)) return m_out[k];
    return 32'd0;
  endfunction

  task automatic m_reset();
    m_ctrl = 0; m_sw = 0; m_seen = 0; m_state = 32'h1;
    for (int k = 0; k < 5; k++) begin m_seed[k] = 0; m_out[k] = 0; end
  endtask

  task automatic m_write(input logic [8:0] a, input logic [31:0] d);
    logic [31:0] f;
    if (a == 9'h000) begin
      m_ctrl = d & ~32'h10;
      if (d[3] && d[4] && m_seen == 5'h1f) begin
        for (int k = 0; k < 5; k++) begin m_state = xs(m_state); m_out[k] = m_state; end
        m_sw[2] = 1'b1;
      end
    end else if (a == 9'h010) begin
      m_sw = d[5:3];
    end else begin
      for (int k = 0; k < 5; k++) if (a == 9'h140 + 9'(4 * k)) begin
        m_seed[k] = d; m_seen[k] = 1'b1;
        f = 0;
        for (int j = 0; j < 5; j++) f = f ^ m_seed[j];
        m_state = (f == 0) ? 32'h1 : f;
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_reset();
  endtask

  task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check(tag, rd_data_o, m_read(a));
  endtask

  task automatic rd_all(input string tag);
    rd_chk(tag, 9'h000);
    rd_chk(tag, 9'h010);
    for (int k = 0; k < 5; k++) rd_chk(tag, 9'h160 + 9'(4 * k));
  endtask

  task automatic load_seeds(input logic [31:0] base);
    for (int k = 0; k < 5; k++) bus_wr(9'h140 + 9'(4 * k), base ^ (32'h1111_1111 * (k + 1)));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd_all("R1 reset");

    // R2 R3: every subset of loaded seed slots
    for (int mask = 0; mask < 32; mask++) begin
      do_reset();
      for (int k = 0; k < 5; k++)
        if (mask[k]) bus_wr(9'h140 + 9'(4 * k), 32'hC0DE_0000 + 32'(mask * 7 + k));
      rd_chk("R2 seed complete flag", 9'h010);
      bus_wr(9'h000, 32'h18);
      rd_all("R3 gated start");
    end

    // R3 R4 R7: sweep low control byte with seeds complete
    do_reset();
    load_seeds(32'h1234_5678);
    for (int v = 0; v < 256; v++) begin
      bus_wr(9'h000, {24'h5A5A00 ^ 24'(v * 3), 8'(v)});
      rd_chk("R4 control readback", 9'h000);
      rd_chk("R3 done flag", 9'h010);
      rd_chk("R7 continued output", 9'h170);
    end
    rd_all("R7 final words");

    // R5 R10: all status write patterns
    for (int v = 0; v < 256; v++) begin
      bus_wr(9'h010, {24'hFFFFFF, 8'(v)});
      rd_chk("R5 R10 status write", 9'h010);
    end

    // R6: seed fold equal to zero uses substitute
    do_reset();
    bus_wr(9'h140, 32'hDEAD_BEEF);
    bus_wr(9'h144, 32'hDEAD_BEEF);
    bus_wr(9'h148, 32'h0F0F_1234);
    bus_wr(9'h14C, 32'h0F0F_1234);
    bus_wr(9'h150, 32'h0);
    bus_wr(9'h000, 32'h18);
    check("R6 zero fold word0", m_out[0], xs(32'h1));
    rd_all("R6 zero fold");
    // R6 nonzero fold, rewrite of a slot
    bus_wr(9'h148, 32'h0000_00FF);
    bus_wr(9'h000, 32'h08);
    rd_all("R6 no go bit");
    bus_wr(9'h000, 32'h18);
    rd_all("R6 reseeded");

    // R8 dead addresses
    bus_wr(9'h000, 32'h0000_0008);
    bus_wr(9'h004, 32'hFFFF_FFFF);
    bus_wr(9'h154, 32'hFFFF_FFFF);
    bus_wr(9'h160, 32'hFFFF_FFFF);
    bus_wr(9'h16C, 32'hFFFF_FFFF);
    bus_wr(9'h142, 32'hFFFF_FFFF);
    bus_wr(9'h1FC, 32'hFFFF_FFFF);
    bus_wr(9'h011, 32'hFFFF_FFFF);
    rd_all("R8 dead writes");
    rd_chk("R8 seed slot reads zero", 9'h140);
    rd_chk("R8 seed slot reads zero", 9'h150);
    rd_chk("R8 unmapped read", 9'h004);
    rd_chk("R8 unmapped read", 9'h1FC);
    rd_chk("R8 misaligned read", 9'h162);

    // R9 idle read data
    rd_chk("R9 read", 9'h000);
    @(negedge clk_i);
    check("R9 idle zero", rd_data_o, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule